// File: doc/BRIEF.md
# Dadda Tree Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits (8 by default) and returns the full `2W`-bit product. It is purely combinational, with no clock, no reset and no handshake. The result settles once the operands are stable.

Inside, the block first builds the full array of single-bit partial products. Each bit is the AND of one operand bit from each side, and the bit is placed in the column given by the sum of the two bit indices. The columns are then compressed through a series of levels. The height limits of these levels come from the sequence 2, 3, 4, 6, 9, ..., where each term is the floor of 1.5 times the previous one. The first level uses the largest limit that is below the tallest column, so for 8-bit operands the limits are 6, 4, 3 and 2.

At each level, a column gets only as many full and half adders as it needs to stay within the limit. That count includes the carries that arrive in the same level from the column below. Full and half adders are separate cell instances, so the reduction can be inspected in the netlist. When the last level is done, no column holds more than two bits. A ripple adder built from full-adder cells sums those two rows to give the product.

Top module: `dadda_mult`

## Requirements
- R1: `p_o` equals the unsigned product of `a_i` and `b_i` for every operand pair, on all `2W` bits.
- R2: If either operand is zero, the product is zero.
- R3: If one operand equals 1, the product equals the other operand, zero-extended.
- R4: When both operands are all ones, the product is (2^W-1)^2, which is 16'hFE01 for W=8.
- R5: When `a_i` = 2^i and `b_i` = 2^j, exactly one product bit is set, and it is bit i+j.
- R6: Every reduction level keeps the weighted sum of its bits equal to the product. The weight of a bit is 2 raised to its column index.
- R7: Swapping the two operands does not change the product.
- R8: The two rows left after the last level add up to the product, and the final adder never produces a carry out of its top column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | W | Multiplicand, unsigned |
| b_i | input | W | Multiplier, unsigned |
| p_o | output | 2*W | Unsigned product |

## Verification
The hardest fault to reach is a misrouted carry or sum deep in the tree. One such case is a half adder in one column whose carry lands in the wrong row of the next column. That fault only shows when the particular partial-product bits feeding that cell are set together, and a few directed values rarely produce that combination. For the default width the bench therefore walks all 65536 operand pairs, which drives every adder input through every value it can take. Seeded random pairs, single-bit operands and swapped pairs are added on top. A per-level weighted-sum check points to the level where a mismatch first appears.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

  // Number of reduction levels for a W x W array: count limits below W.
  function automatic int num_stages(input int w);
    int d;
    int n;
    d = 2;
    n = 0;
    while (d < w) begin
      n++;
      d = (d * 3) / 2;
    end
    return n;
  endfunction

  // Height limit of level s (s = 0 is the first, tallest limit).
  function automatic int stage_limit(input int w, input int s);
    int d;
    int n;
    n = num_stages(w);
    d = 2;
    for (int k = 1; k < n - s; k++) d = (d * 3) / 2;
    return d;
  endfunction

  // Initial partial-product count in column c.
  function automatic int col_pp(input int w, input int c);
    if (c < w) return c + 1;
    else if (c <= 2 * w - 2) return 2 * w - 1 - c;
    else return 0;
  endfunction

  // Column height at the input of level s (s = num_stages gives final rows).
  function automatic int level_height(input int w, input int s, input int c);
    int h [256];
    int lim, cin, tot, ex, f, hh;
    for (int col = 0; col < 2 * w; col++) h[col] = col_pp(w, col);
    for (int t = 0; t < s; t++) begin
      lim = stage_limit(w, t);
      cin = 0;
      for (int col = 0; col < 2 * w; col++) begin
        tot = h[col] + cin;
        ex  = tot - lim;
        f   = 0;
        hh  = 0;
        if (ex > 0) begin
          f  = ex / 2;
          hh = ex % 2;
        end
        h[col] = h[col] - 2 * f - hh + cin;
        cin    = f + hh;
      end
    end
    return h[c];
  endfunction

  // Adders of level s in column c: kind 0 = full adders, 1 = half adders.
  function automatic int adder_count(input int w, input int s, input int c,
                                     input int kind);
    int lim, cin, tot, ex, f, hh;
    lim = stage_limit(w, s);
    cin = 0;
    f   = 0;
    hh  = 0;
    for (int col = 0; col <= c; col++) begin
      tot = level_height(w, s, col) + cin;
      ex  = tot - lim;
      f   = 0;
      hh  = 0;
      if (ex > 0) begin
        f  = ex / 2;
        hh = ex % 2;
      end
      cin = f + hh;
    end
    return (kind == 0) ? f : hh;
  endfunction

endpackage

// File: rtl/dadda_cells.sv
module dadda_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ z_i;
  assign c_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);
endmodule

module dadda_ha (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;
endmodule

// File: rtl/dadda_pp_array.sv
module dadda_pp_array import dadda_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0]            a_i,
  input  logic [W-1:0]            b_i,
  output logic [2*W-1:0][W-1:0]   col_o
);
  localparam int COLS = 2 * W;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int LO  = (c < W) ? 0 : c - W + 1;
    localparam int HGT = col_pp(W, c);
    for (genvar r = 0; r < W; r++) begin : g_row
      if (r < HGT) begin : g_bit
        assign col_o[c][r] = a_i[LO+r] & b_i[c-LO-r];
      end else begin : g_zero
        assign col_o[c][r] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dadda_stage.sv
module dadda_stage import dadda_pkg::*; #(
  parameter int W = 8,
  parameter int S = 0
) (
  input  logic [2*W-1:0][W-1:0] col_i,
  output logic [2*W-1:0][W-1:0] col_o
);
  localparam int COLS = 2 * W;

  logic [COLS-1:0][W-1:0] sm;
  logic [COLS-1:0][W-1:0] cy;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam int HIN = level_height(W, S, c);
    localparam int F   = adder_count(W, S, c, 0);
    localparam int HA  = adder_count(W, S, c, 1);
    localparam int CI  = (c > 0) ? adder_count(W, S, c - 1, 0)
                                 + adder_count(W, S, c - 1, 1) : 0;
    localparam int P   = HIN - 3 * F - 2 * HA;
    localparam int USED = 3 * F + 2 * HA;

    // adder cells: full adders first, then half adders
    for (genvar k = 0; k < W; k++) begin : g_add
      if (k < F) begin : g_fa
        dadda_fa u_fa (
          .x_i(col_i[c][3*k]),
          .y_i(col_i[c][3*k+1]),
          .z_i(col_i[c][3*k+2]),
          .s_o(sm[c][k]),
          .c_o(cy[c][k])
        );
      end else if (k < F + HA) begin : g_ha
        dadda_ha u_ha (
          .x_i(col_i[c][3*F+2*(k-F)]),
          .y_i(col_i[c][3*F+2*(k-F)+1]),
          .s_o(sm[c][k]),
          .c_o(cy[c][k])
        );
      end else begin : g_none
        assign sm[c][k] = 1'b0;
        assign cy[c][k] = 1'b0;
      end
    end

    // output rows: pass-through bits, own sums, carries from column below
    for (genvar r = 0; r < W; r++) begin : g_row
      if (r < P) begin : g_pass
        assign col_o[c][r] = col_i[c][USED+r];
      end else if (r < P + F + HA) begin : g_sum
        assign col_o[c][r] = sm[c][r-P];
      end else if ((c > 0) && (r < P + F + HA + CI)) begin : g_carry
        assign col_o[c][r] = cy[c-1][r-P-F-HA];
      end else begin : g_zero
        assign col_o[c][r] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa #(
  parameter int N = 16
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  output logic [N-1:0] s_o,
  output logic         co_o
);
  logic [N:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    dadda_fa u_fa (
      .x_i(x_i[i]),
      .y_i(y_i[i]),
      .z_i(carry[i]),
      .s_o(s_o[i]),
      .c_o(carry[i+1])
    );
  end

  assign co_o = carry[N];
endmodule

// File: rtl/dadda_mult.sv
module dadda_mult import dadda_pkg::*; #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int COLS = 2 * W;
  localparam int NST  = num_stages(W);

  logic [COLS-1:0][W-1:0] lvl [NST+1];
  logic [COLS-1:0]        row_a;
  logic [COLS-1:0]        row_b;
  logic                   cpa_cout;

  dadda_pp_array #(.W(W)) u_pp (
    .a_i  (a_i),
    .b_i  (b_i),
    .col_o(lvl[0])
  );

  for (genvar s = 0; s < NST; s++) begin : g_stage
    dadda_stage #(.W(W), .S(s)) u_stage (
      .col_i(lvl[s]),
      .col_o(lvl[s+1])
    );
  end

  for (genvar c = 0; c < COLS; c++) begin : g_rows
    assign row_a[c] = lvl[NST][c][0];
    assign row_b[c] = lvl[NST][c][1];
  end

  dadda_cpa #(.N(COLS)) u_cpa (
    .x_i (row_a),
    .y_i (row_b),
    .s_o (p_o),
    .co_o(cpa_cout)
  );
endmodule

// File: rtl/dadda_mult_chk.sv
module dadda_mult_chk import dadda_pkg::*; #(
  parameter int W   = 8,
  parameter int NST = num_stages(W)
) (
  input logic [W-1:0]             a_i,
  input logic [W-1:0]             b_i,
  input logic [2*W-1:0]           p_o,
  input logic [2*W-1:0][W-1:0]    lvl [NST+1],
  input logic [2*W-1:0]           row_a,
  input logic [2*W-1:0]           row_b,
  input logic                     cpa_cout
);
  localparam int COLS = 2 * W;

  function automatic logic [COLS-1:0] weigh(input logic [COLS-1:0][W-1:0] v);
    logic [COLS-1:0] acc;
    acc = '0;
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < W; r++)
        if (v[c][r]) acc = acc + (COLS'(1) << c);
    return acc;
  endfunction

  logic [COLS-1:0] ref_prod;
  assign ref_prod = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};

  always_comb begin
    // R1
    prod_match_chk: assert (p_o == ref_prod)
      else $error("product %0h differs from %0h", p_o, ref_prod);
    // R2
    zero_operand_chk: assert (!((a_i == '0) || (b_i == '0)) || (p_o == '0))
      else $error("zero operand gave %0h", p_o);
    // R3
    unit_operand_chk: assert (!(a_i == W'(1)) || (p_o == {{W{1'b0}}, b_i}))
      else $error("unit operand gave %0h", p_o);
    // R5
    single_bit_chk: assert (!(($countones(a_i) == 1) && ($countones(b_i) == 1))
                            || $onehot(p_o))
      else $error("single-bit operands gave %0h", p_o);
    // R8
    rows_sum_chk: assert ((row_a + row_b) == p_o)
      else $error("final rows do not add to product");
    // R8
    cpa_cout_chk: assert (cpa_cout == 1'b0)
      else $error("carry out of final adder");
  end

  for (genvar s = 0; s <= NST; s++) begin : g_lvl
    always_comb begin
      // R6
      level_sum_chk: assert (weigh(lvl[s]) == ref_prod)
        else $error("level %0d weighted sum wrong", s);
    end
  end
endmodule

bind dadda_mult dadda_mult_chk #(.W(W)) i_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .p_o     (p_o),
  .lvl     (lvl),
  .row_a   (row_a),
  .row_b   (row_b),
  .cpa_cout(cpa_cout)
);

// File: tb/test_dadda_mult.sv
module test_dadda_mult;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int WD_LIMIT   = 150000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [W-1:0]   a_r = '0;
  logic [W-1:0]   b_r = '0;
  logic [2*W-1:0] p_w;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  dadda_mult #(.W(W)) i_dadda_mult (
    .a_i(a_r),
    .b_i(b_r),
    .p_o(p_w)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // shift-and-add reference
  function automatic logic [2*W-1:0] exp_mul(input logic [W-1:0] a,
                                             input logic [W-1:0] b);
    logic [2*W-1:0] acc;
    acc = '0;
    for (int j = 0; j < W; j++)
      if (b[j]) acc = acc + ({{W{1'b0}}, a} << j);
    return acc;
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst_n) cycles <= cycles + 1;
    if (cycles > WD_LIMIT && !done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected <= %0d",
               cycles, WD_LIMIT);
      finish_run();
    end
  end

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk);
    #1;
    a_r = a;
    b_r = b;
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2*W-1:0] exp);
    n_tests++;
    if (p_w !== exp) begin
      n_fail++;
      $display("FAIL %s a=%0d b=%0d actual=%0h expected=%0h",
               req, a_r, b_r, p_w, exp);
    end
  endtask

  initial begin
    logic [2*W-1:0] first;
    void'($urandom(32'h0000_5EED));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // starting state: zero operands give zero (R2)
    @(negedge clk);
    check("R2 start", '0);

    // R2: zero on either side
    apply(8'd0, 8'd173); check("R2", '0);
    apply(8'd91, 8'd0);  check("R2", '0);
    apply(8'd0, 8'd255); check("R2", '0);

    // R3: unit operand
    apply(8'd1, 8'd200); check("R3", 16'd200);
    apply(8'd255, 8'd1); check("R3", 16'd255);

    // R4: all ones
    apply(8'hFF, 8'hFF); check("R4", 16'hFE01);
    apply(8'hFF, 8'hFE); check("R4", 16'hFD02);

    // R5: single set bit on each side lands at column i+j
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++) begin
        apply(W'(1) << i, W'(1) << j);
        check("R5", (2*W)'(1) << (i + j));
      end

    // R7: swapped operands give the same product
    for (int k = 0; k < 200; k++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      apply(x, y);
      first = p_w;
      apply(y, x);
      check("R7", first);
    end

    // R1: seeded random pairs
    for (int k = 0; k < 2000; k++) begin
      logic [W-1:0] x, y;
      x = W'($urandom);
      y = W'($urandom);
      apply(x, y);
      check("R1", exp_mul(x, y));
    end

    // R1 R6 R8: every operand pair
    for (int x = 0; x < (1 << W); x++)
      for (int y = 0; y < (1 << W); y++) begin
        apply(W'(x), W'(y));
        check("R1 R6 R8", exp_mul(W'(x), W'(y)));
      end

    done = 1'b1;
    finish_run();
  end
endmodule